// File: doc/BRIEF.md
# ECC-protected local memory slave

This block is a single-port on-chip memory that answers a simple synchronous 32-bit processor local bus. A request carries a read or write flag, a word address, four byte enables and write data. The block answers with a one-cycle Ready pulse, and a Wait level during the extra cycle of a longer access. Every stored word holds 32 data bits and seven check bits of a single-error-correct, double-error-detect Hamming code. The check bits are written with the data, checked on every read, and any single-bit fault is corrected before the data leaves the block.

A write with all four byte enables set stores a freshly encoded word in one cycle. A write with any lane disabled first reads the stored word and decodes it. The new lanes are then merged over the corrected old word, and the result is written back with new check bits. On reads and on these sub-word writes the block reports a correctable or an uncorrectable flag alongside Ready. An error injection mask on the write path lets a test corrupt chosen stored bits.

Top module: `ecc_lmem`

## Requirements
- R1: While rst_n is low, and in the first cycle after it rises with no request, rsp_ready, rsp_wait, rsp_ce and rsp_ue are all low.
- R2: A read accepted at a rising edge (req_valid high, rsp_wait low) gives rsp_ready high with rsp_wait low in the next cycle. rsp_rdata then equals the word last written to that address.
- R3: A write with req_be = 4'b1111 gives rsp_ready one cycle after acceptance, with rsp_wait, rsp_ce and rsp_ue low, even if the word it replaces was corrupt.
- R4: A write with any req_be bit low holds rsp_wait high for exactly one cycle, then gives rsp_ready. Only the lanes whose enable is set change, where req_be bit n selects data bits 8n+7..8n (bit 0 is the lowest-address byte). With req_be = 4'b0000 the word is left unchanged.
- R5: If exactly one bit of a stored codeword is flipped, a read returns the originally written data with rsp_ce high and rsp_ue low. inj_mask bit i flips codeword bit i when the word is written: bits 31..0 are the data bits, 37..32 the Hamming check bits and bit 38 the overall parity.
- R6: If exactly two codeword bits are flipped, a read reports rsp_ue high and rsp_ce low, and returns the stored data bits without correction.
- R7: A sub-word write to a word with one flipped bit reports rsp_ce high with Ready. It merges the new lanes over the corrected old word, and a later read of that word reports no error.
- R8: A sub-word write to a word with two flipped bits reports rsp_ue high with Ready. It still writes the merged word, built from the uncorrected old data, with fresh check bits, so a later read returns it with no error flag.
- R9: Whenever rsp_ready is low, rsp_ce, rsp_ue and rsp_rdata are all zero. rsp_rdata is also zero in the Ready cycle of a write.
- R10: A request presented in the cycle where rsp_ready is high is accepted at the next edge. A request presented while rsp_wait is high is ignored and changes no stored word.
- R11: rsp_ready and rsp_wait are never high in the same cycle, and rsp_ce and rsp_ue are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word address, AW = clog2(DEPTH) |
| req_be | input | 4 | Byte lane enables for writes, bit 0 = lowest byte |
| req_wdata | input | 32 | Write data |
| inj_mask | input | 39 | XOR mask applied to the codeword as it is stored |
| rsp_rdata | output | 32 | Corrected read data, valid with rsp_ready |
| rsp_ready | output | 1 | Transfer complete this cycle |
| rsp_wait | output | 1 | Transfer accepted, not yet complete |
| rsp_ce | output | 1 | Correctable error on this transfer, valid with rsp_ready |
| rsp_ue | output | 1 | Uncorrectable error on this transfer, valid with rsp_ready |

## Verification
The bound checker watches the handshake on every cycle. It checks that Ready follows a read or full-word write by one cycle and that sub-word writes raise Wait for exactly one cycle before Ready. It also checks that Ready and Wait stay exclusive, that the two error flags stay exclusive, and that flags and read data are silent outside Ready. Data integrity can only be shown by the bench's scenarios: lane merging, correction of each of the 39 codeword bits, detection of double faults, and the state a sub-word write leaves behind after a corrected or a corrupt old word. The same holds for ignoring a request made during Wait, which the bench sees only by reading the word back.

// File: rtl/ecc_lmem_pkg.sv
// Shared widths, state type and the Hamming position helpers for the
// ECC local memory. Assumes a 32-bit data word and a (39,32) code.
package ecc_lmem_pkg;
    localparam int DW    = 32;          // data bits per word
    localparam int PW    = 6;           // Hamming check bits
    localparam int CW    = DW + PW + 1; // codeword incl. overall parity
    localparam int LANES = DW / 8;      // byte lanes

    typedef enum logic { ST_IDLE, ST_MERGE } lmem_state_e;

    // Hamming position (1-based, skipping powers of two) of data bit idx.
    function automatic int data_pos(input int idx);
        int cnt;
        int res;
        cnt = 0;
        res = 0;
        for (int p = 1; p <= DW + PW; p++) begin
            if ((p & (p - 1)) != 0) begin
                if (cnt == idx) res = p;
                cnt++;
            end
        end
        return res;
    endfunction

    // Hamming check bits over a data word.
    function automatic logic [PW-1:0] hamming_checks(input logic [DW-1:0] d);
        logic [PW-1:0] c;
        int p;
        c = '0;
        for (int i = 0; i < DW; i++) begin
            p = data_pos(i);
            for (int k = 0; k < PW; k++) begin
                if (p[k]) c[k] = c[k] ^ d[i];
            end
        end
        return c;
    endfunction
endpackage

// File: rtl/ecc_lmem_enc.sv
// SECDED encoder: builds the codeword {overall parity, checks, data}.
// Purely combinational; assumes the package layout.
module ecc_lmem_enc
    import ecc_lmem_pkg::*;
(
    input  logic [DW-1:0] data,
    output logic [CW-1:0] code
);
    logic [PW-1:0] chk;

    // Compute check bits and the overall parity over all other bits.
    always_comb begin
        chk  = hamming_checks(data);
        code = {^{chk, data}, chk, data};
    end
endmodule

// File: rtl/ecc_lmem_dec.sv
// SECDED decoder: corrects a single flipped bit anywhere in the codeword,
// flags double faults and invalid syndromes as uncorrectable, and passes
// the raw data through when the word cannot be corrected.
module ecc_lmem_dec
    import ecc_lmem_pkg::*;
(
    input  logic [CW-1:0] code,
    output logic [DW-1:0] data,
    output logic          ce,
    output logic          ue
);
    logic [PW-1:0] syn;
    logic          par;
    logic [DW-1:0] flip;
    logic          good_single;

    // Syndrome and overall parity of the received word.
    always_comb begin
        syn = code[DW+PW-1:DW] ^ hamming_checks(code[DW-1:0]);
        par = ^code;
    end

    // One flip enable per data bit, matched on its Hamming position.
    for (genvar i = 0; i < DW; i++) begin : g_flip
        localparam logic [PW-1:0] POS = PW'(data_pos(i));
        assign flip[i] = par && (syn == POS);
    end

    // Classify the fault and apply the correction.
    always_comb begin
        good_single = par && ((syn == '0) || ((syn & (syn - 1'b1)) == '0) || (|flip));
        ce   = good_single;
        ue   = (!par && (syn != '0)) || (par && !good_single);
        data = code[DW-1:0] ^ flip;
    end
endmodule

// File: rtl/ecc_lmem_array.sv
// Single-port storage array with a registered read port. A write does not
// update the read register. Contents are not reset.
module ecc_lmem_array #(
    parameter int DEPTH = 256,
    parameter int WIDTH = 39,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             en,
    input  logic             we,
    input  logic [AW-1:0]    addr,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem [DEPTH];

    // One access per cycle: write the word or register the read.
    always_ff @(posedge clk) begin
        if (en) begin
            if (we) mem[addr] <= wdata;
            else    rdata     <= mem[addr];
        end
    end
endmodule

// File: rtl/ecc_lmem.sv
// ECC local memory slave. Accepts a request when not busy. Reads and
// full-word writes answer with Ready one cycle later. Sub-word writes read
// the old word, raise Wait for one cycle, then merge the new lanes over the
// decoded old data and write back with new check bits. Assumes the
// requester watches Ready/Wait and does not expect requests made during
// Wait to be taken.
module ecc_lmem
    import ecc_lmem_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [AW-1:0]    req_addr,
    input  logic [LANES-1:0] req_be,
    input  logic [DW-1:0]    req_wdata,
    input  logic [CW-1:0]    inj_mask,
    output logic [DW-1:0]    rsp_rdata,
    output logic             rsp_ready,
    output logic             rsp_wait,
    output logic             rsp_ce,
    output logic             rsp_ue
);
    lmem_state_e      state_q;
    logic             accept, full_wr, part_wr;
    logic [AW-1:0]    addr_q;
    logic [LANES-1:0] be_q;
    logic [DW-1:0]    wdata_q;
    logic             ready_q, rd_resp_q, mrg_ce_q, mrg_ue_q;

    logic             arr_en, arr_we;
    logic [AW-1:0]    arr_addr;
    logic [CW-1:0]    arr_wdata, arr_rdata, enc_code;
    logic [DW-1:0]    enc_in, dec_data, merged;
    logic             dec_ce, dec_ue;

    // Request classification.
    always_comb begin
        accept  = req_valid && (state_q == ST_IDLE);
        full_wr = req_write && (req_be == {LANES{1'b1}});
        part_wr = req_write && !full_wr;
    end

    // Lane merge of new bytes over the decoded old word.
    for (genvar b = 0; b < LANES; b++) begin : g_lane
        assign merged[8*b +: 8] = be_q[b] ? wdata_q[8*b +: 8] : dec_data[8*b +: 8];
    end

    // Array port steering: merge write-back has priority over new requests.
    always_comb begin
        enc_in    = (state_q == ST_MERGE) ? merged : req_wdata;
        arr_wdata = enc_code ^ inj_mask;
        if (state_q == ST_MERGE) begin
            arr_en   = 1'b1;
            arr_we   = 1'b1;
            arr_addr = addr_q;
        end else begin
            arr_en   = accept;
            arr_we   = full_wr;
            arr_addr = req_addr;
        end
    end

    ecc_lmem_enc u_enc (.data(enc_in), .code(enc_code));

    ecc_lmem_array #(.DEPTH(DEPTH), .WIDTH(CW)) u_arr (
        .clk  (clk),
        .en   (arr_en),
        .we   (arr_we),
        .addr (arr_addr),
        .wdata(arr_wdata),
        .rdata(arr_rdata)
    );

    ecc_lmem_dec u_dec (.code(arr_rdata), .data(dec_data), .ce(dec_ce), .ue(dec_ue));

    // Sequencer and response registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            ready_q   <= 1'b0;
            rd_resp_q <= 1'b0;
            mrg_ce_q  <= 1'b0;
            mrg_ue_q  <= 1'b0;
            addr_q    <= '0;
            be_q      <= '0;
            wdata_q   <= '0;
        end else begin
            ready_q   <= (accept && !part_wr) || (state_q == ST_MERGE);
            rd_resp_q <= accept && !req_write;
            mrg_ce_q  <= (state_q == ST_MERGE) && dec_ce;
            mrg_ue_q  <= (state_q == ST_MERGE) && dec_ue;
            if (accept) begin
                addr_q  <= req_addr;
                be_q    <= req_be;
                wdata_q <= req_wdata;
            end
            if (state_q == ST_MERGE)    state_q <= ST_IDLE;
            else if (accept && part_wr) state_q <= ST_MERGE;
        end
    end

    // Response outputs, silent outside the Ready cycle.
    always_comb begin
        rsp_ready = ready_q;
        rsp_wait  = (state_q == ST_MERGE);
        rsp_rdata = (ready_q && rd_resp_q) ? dec_data : '0;
        rsp_ce    = ready_q && (rd_resp_q ? dec_ce : mrg_ce_q);
        rsp_ue    = ready_q && (rd_resp_q ? dec_ue : mrg_ue_q);
    end
endmodule

// File: rtl/ecc_lmem_chk.sv
// Handshake checker for the ECC local memory, attached by bind.
module ecc_lmem_chk
    import ecc_lmem_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_write,
    input logic [LANES-1:0] req_be,
    input logic [DW-1:0]    rsp_rdata,
    input logic             rsp_ready,
    input logic             rsp_wait,
    input logic             rsp_ce,
    input logic             rsp_ue
);
    AST_RDY_WAIT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_ready && rsp_wait)); // R11
    AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_ce && rsp_ue)); // R11
    AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_ready |-> (!rsp_ce && !rsp_ue && rsp_rdata == '0)); // R9
    AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !rsp_wait && !req_write) |=> (rsp_ready && !rsp_wait)); // R2
    AST_FULL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !rsp_wait && req_write && req_be == {LANES{1'b1}})
        |=> (rsp_ready && !rsp_wait && !rsp_ce && !rsp_ue)); // R3
    AST_PART_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !rsp_wait && req_write && req_be != {LANES{1'b1}})
        |=> (rsp_wait && !rsp_ready)); // R4
    AST_WAIT_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_wait |=> (!rsp_wait && rsp_ready)); // R4
endmodule

bind ecc_lmem ecc_lmem_chk u_chk (.*);

// File: tb/tb_ecc_lmem.sv
// Directed bench for the ECC local memory slave.
module tb_ecc_lmem;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 64;
    localparam int AW = $clog2(DEPTH);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0, req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [3:0]    req_be = '0;
    logic [31:0]   req_wdata = '0;
    logic [38:0]   inj_mask = '0;
    logic [31:0]   rsp_rdata;
    logic          rsp_ready, rsp_wait, rsp_ce, rsp_ue;
    int total = 0, bad = 0;

    ecc_lmem #(.DEPTH(DEPTH)) dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] nw, input logic [3:0] be);
        logic [31:0] r;
        for (int b = 0; b < 4; b++) r[8*b +: 8] = be[b] ? nw[8*b +: 8] : old[8*b +: 8];
        return r;
    endfunction

    task automatic drive(input bit w, input int a, input logic [3:0] be, input logic [31:0] d, input logic [38:0] m);
        req_valid = 1'b1; req_write = w; req_addr = AW'(a); req_be = be; req_wdata = d; inj_mask = m;
    endtask

    task automatic idle();
        req_valid = 1'b0; inj_mask = '0;
    endtask

    task automatic wr_full(input int a, input logic [31:0] d, input logic [38:0] m);
        @(negedge clk); drive(1, a, 4'hF, d, m);
        @(negedge clk); idle();
        check(rsp_ready === 1'b1 && rsp_wait === 1'b0, "R3 full write ready", {rsp_ready, rsp_wait}, 2'b10);
        check(rsp_ce === 1'b0 && rsp_ue === 1'b0 && rsp_rdata === 32'h0, "R3 R9 full write flags/data", {rsp_ce, rsp_ue, rsp_rdata}, 0);
    endtask

    task automatic rd(input int a, output logic [31:0] d, output logic ce, output logic ue);
        @(negedge clk); drive(0, a, 4'h0, 32'h0, '0);
        @(negedge clk); idle();
        check(rsp_ready === 1'b1 && rsp_wait === 1'b0, "R2 read ready", {rsp_ready, rsp_wait}, 2'b10);
        d = rsp_rdata; ce = rsp_ce; ue = rsp_ue;
    endtask

    task automatic wr_part(input int a, input logic [3:0] be, input logic [31:0] d, output logic ce, output logic ue);
        @(negedge clk); drive(1, a, be, d, '0);
        @(negedge clk); idle();
        check(rsp_wait === 1'b1 && rsp_ready === 1'b0, "R4 R11 partial wait cycle", {rsp_wait, rsp_ready}, 2'b10);
        check(rsp_ce === 1'b0 && rsp_ue === 1'b0, "R9 flags quiet during wait", {rsp_ce, rsp_ue}, 0);
        @(negedge clk);
        check(rsp_ready === 1'b1 && rsp_wait === 1'b0, "R4 partial ready", {rsp_ready, rsp_wait}, 2'b10);
        check(rsp_rdata === 32'h0, "R9 partial write data zero", rsp_rdata, 0);
        ce = rsp_ce; ue = rsp_ue;
    endtask

    task automatic t_reset();
        idle();
        repeat (3) @(negedge clk);
        check({rsp_ready, rsp_wait, rsp_ce, rsp_ue} === 4'b0, "R1 outputs in reset", {rsp_ready, rsp_wait, rsp_ce, rsp_ue}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check({rsp_ready, rsp_wait, rsp_ce, rsp_ue} === 4'b0, "R1 outputs after reset", {rsp_ready, rsp_wait, rsp_ce, rsp_ue}, 0);
    endtask

    task automatic t_basic();
        logic [31:0] d; logic ce, ue;
        logic [31:0] pat [4] = '{32'h0000_0000, 32'hFFFF_FFFF, 32'hA5A5_5A5A, 32'h1234_5678};
        for (int i = 0; i < 4; i++) wr_full(i * 7, pat[i], '0);
        for (int i = 0; i < 4; i++) begin
            rd(i * 7, d, ce, ue);
            check(d === pat[i] && !ce && !ue, "R2 read back clean word", {ce, ue, d}, {2'b00, pat[i]});
        end
    endtask

    task automatic t_partial();
        logic [31:0] d; logic ce, ue;
        wr_full(3, 32'h1122_3344, '0);
        wr_part(3, 4'b0001, 32'hAABB_CCDD, ce, ue);
        check(!ce && !ue, "R4 partial clean flags", {ce, ue}, 0);
        wr_part(3, 4'b1100, 32'h5566_7788, ce, ue);
        rd(3, d, ce, ue);
        check(d === 32'h5566_33DD, "R4 lane merge", d, 32'h5566_33DD);
        wr_part(3, 4'b0000, 32'hFFFF_FFFF, ce, ue);
        rd(3, d, ce, ue);
        check(d === 32'h5566_33DD && !ce && !ue, "R4 empty enables keep word", d, 32'h5566_33DD);
    endtask

    task automatic t_single();
        logic [31:0] d, w; logic ce, ue;
        for (int i = 0; i < 39; i++) begin
            w = 32'h3C96_0F51 ^ (32'h0101_0101 * i);
            wr_full(8, w, 39'd1 << i);
            rd(8, d, ce, ue);
            check(d === w && ce === 1'b1 && ue === 1'b0, $sformatf("R5 single flip bit %0d", i), {ce, ue, d}, {2'b10, w});
        end
    endtask

    task automatic t_double();
        logic [31:0] d, w; logic ce, ue; logic [38:0] m;
        int pa [4] = '{0, 5, 32, 20};
        int pb [4] = '{1, 35, 38, 31};
        for (int i = 0; i < 4; i++) begin
            w = 32'hC0DE_0000 + i;
            m = (39'd1 << pa[i]) | (39'd1 << pb[i]);
            wr_full(9, w, m);
            rd(9, d, ce, ue);
            check(ue === 1'b1 && ce === 1'b0, $sformatf("R6 double flip %0d/%0d flags", pa[i], pb[i]), {ce, ue}, 2'b01);
            check(d === (w ^ m[31:0]), "R6 raw data returned", d, w ^ m[31:0]);
        end
        wr_full(9, 32'h7777_0000, '0);
        rd(9, d, ce, ue);
        check(d === 32'h7777_0000 && !ce && !ue, "R3 full write over corrupt word", {ce, ue, d}, 32'h7777_0000);
    endtask

    task automatic t_part_single();
        logic [31:0] d, exp; logic ce, ue;
        wr_full(12, 32'hDEAD_BEEF, 39'd1 << 3);
        wr_part(12, 4'b0010, 32'h0000_5500, ce, ue);
        check(ce === 1'b1 && ue === 1'b0, "R7 partial over single fault flags", {ce, ue}, 2'b10);
        exp = merge(32'hDEAD_BEEF, 32'h0000_5500, 4'b0010);
        rd(12, d, ce, ue);
        check(d === exp && !ce && !ue, "R7 merged over corrected word", {ce, ue, d}, exp);
    endtask

    task automatic t_part_double();
        logic [31:0] d, exp; logic ce, ue; logic [38:0] m;
        m = (39'd1 << 2) | (39'd1 << 9);
        wr_full(13, 32'h0BAD_F00D, m);
        wr_part(13, 4'b1000, 32'h9900_0000, ce, ue);
        check(ue === 1'b1 && ce === 1'b0, "R8 partial over double fault flags", {ce, ue}, 2'b01);
        exp = merge(32'h0BAD_F00D ^ m[31:0], 32'h9900_0000, 4'b1000);
        rd(13, d, ce, ue);
        check(d === exp && !ce && !ue, "R8 merged word re-encoded", {ce, ue, d}, exp);
    endtask

    task automatic t_b2b();
        logic [31:0] d; logic ce, ue;
        @(negedge clk); drive(1, 20, 4'hF, 32'hFACE_CAFE, '0);
        @(negedge clk);
        check(rsp_ready === 1'b1, "R10 write ready before chained read", rsp_ready, 1);
        drive(0, 20, 4'h0, 32'h0, '0);
        @(negedge clk); idle();
        check(rsp_ready === 1'b1 && rsp_rdata === 32'hFACE_CAFE, "R10 chained read", {rsp_ready, rsp_rdata}, {1'b1, 32'hFACE_CAFE});
        wr_full(21, 32'h1111_2222, '0);
        @(negedge clk); drive(1, 22, 4'b0001, 32'h0000_00AA, '0);
        @(negedge clk);
        check(rsp_wait === 1'b1, "R10 wait before ignored request", rsp_wait, 1);
        drive(1, 21, 4'hF, 32'h9999_9999, '0);
        @(negedge clk); idle();
        check(rsp_ready === 1'b1, "R10 ready after wait", rsp_ready, 1);
        @(negedge clk);
        check(rsp_ready === 1'b0 && rsp_wait === 1'b0, "R10 no response for ignored request", {rsp_ready, rsp_wait}, 0);
        rd(21, d, ce, ue);
        check(d === 32'h1111_2222, "R10 request during wait ignored", d, 32'h1111_2222);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_basic();
        t_partial();
        t_single();
        t_double();
        t_part_single();
        t_part_double();
        t_b2b();
        repeat (2) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule